// File: doc/BRIEF.md
# Sampling Phase Tuning Sweep Controller

This block searches for the most robust clock sampling phase of a card interface. It steps through a set of N equally spaced phase indices. For each index it asks an external delay unit to apply that phase, waits for the acknowledge, and then asks an external command engine to run one tuning-block transfer, which answers pass or fail. Once the sweep is over, the controller picks a final phase and programs it through the same phase-set handshake.

Phase index i stands for ceil(i*360/N) degrees. Passing indices form contiguous windows. A window that runs off the top end and continues at index 0 counts as one window. The controller programs the centre of the longest window. When every index passes, it programs a caller-supplied default phase instead. When no index passes, it reports an error and programs nothing. A failing index makes the sweep jump ahead by roughly twenty degrees, because testing phases next to a bad one costs time.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: After reset, done, error, set_req and test_req are low and result_deg is 0.
- R2: For each visited index i, set_req is raised with set_deg = ceil(i*360/N). Both stay stable until set_ack is seen. test_req is raised only after that acknowledge and stays high until test_done. set_req and test_req are never high together.
- R3: The sweep starts at index 0. A passing result moves it to the next index.
- R4: A failing result at an index below N-1 moves the sweep ahead by ceil(20*N/360), clamped to N-1. The sweep ends once index N-1 has been tested, so that index is always tested.
- R5: If no index passed, done pulses with error high. No final phase-set is issued and result_deg is 0.
- R6: If there is more than one passing window, and both index 0 and the last tested index passed, the last window and the first window are treated as one window that wraps through index 0.
- R7: If the first window (after merging) covers index 0 through N-1, the final phase-set carries dflt_phase and result_deg equals dflt_phase.
- R8: Otherwise the longest window is chosen. Length is end-start+1, plus N when wrapped. On equal lengths the earlier window wins, where the merged window counts as first. The final phase is the index (start+length/2) mod N, written in degrees by the R2 formula. It is programmed through the phase-set handshake and then reported on result_deg.
- R9: done is a one-cycle pulse. error and result_deg are cleared when a sweep begins and otherwise keep their values. A start pulse during a sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sweep when the block is idle |
| num_phases | input | $clog2(MAX_N+1) | Number of phase indices N, from 1 to MAX_N; sampled at start |
| dflt_phase | input | DEG_W | Phase in degrees used when every index passes; sampled at start |
| set_req | output | 1 | Phase-set request |
| set_deg | output | DEG_W | Phase in degrees for the current request |
| set_ack | input | 1 | Phase applied; one-cycle acknowledge |
| test_req | output | 1 | Tuning-transfer request |
| test_done | input | 1 | Tuning transfer finished; one-cycle strobe |
| test_pass | input | 1 | Transfer result, valid with test_done |
| done | output | 1 | One-cycle end-of-sweep pulse |
| error | output | 1 | No passing phase was found |
| result_deg | output | DEG_W | Final programmed phase in degrees |

## Verification
A corrupted sweep index shows up at the very next phase-set request as a set_deg value that does not match the expected sequence. The bench compares every request against a reference sweep run on the same pass mask. Damage to the window bookkeeping (open flag, count, first-pass flag, the stored window bounds) stays hidden until the end of the sweep. It then appears in the final phase-set value, in the error flag, or as a default phase returned where a computed one was due. Directed masks cover the wrap merge, ties, a pass only at the last index, and single-index sweeps, so each bookkeeping path is forced to decide the outcome at least once.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_TEST,
    ST_EVAL,
    ST_FSET,
    ST_FIN
  } tune_state_t;
endpackage

// File: rtl/tune_phase_map.sv
// Index to degrees: ceil(idx*360/n), combinational.
module tune_phase_map #(
  parameter int NW    = 9,
  parameter int DEG_W = 9
) (
  input  logic [NW-1:0]    idx,
  input  logic [NW-1:0]    n,
  output logic [DEG_W-1:0] deg
);
  localparam int PW = NW + 10;

  logic [PW-1:0] num;

  always_comb begin
    num = PW'(idx) * PW'(360) + PW'(n) - PW'(1);
    deg = DEG_W'(num / PW'(n));
  end
endmodule

// File: rtl/tune_range_track.sv
// Online window tracking: first window, best closed middle window, open window.
module tune_range_track #(
  parameter int NW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          obs_en,
  input  logic [NW-1:0] obs_idx,
  input  logic          obs_pass,
  input  logic [NW-1:0] n,
  output logic          none_found,
  output logic          all_pass,
  output logic [NW-1:0] pick_idx
);
  localparam int LW = NW + 2;

  logic          first_q, first_d, prev_q, prev_d, mvld_q, mvld_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [NW-1:0] r0s_q, r0s_d, r0e_q, r0e_d, curs_q, curs_d, cure_q, cure_d, mids_q, mids_d;
  logic [LW-1:0] midl_q, midl_d, cur_len;
  logic          upd;

  function automatic logic [LW-1:0] span(input logic [NW-1:0] s, input logic [NW-1:0] e,
                                         input logic [NW-1:0] nn);
    logic [LW-1:0] r;
    r = LW'(e) - LW'(s) + LW'(1);
    if (r[LW-1]) r = r + LW'(nn);
    return r;
  endfunction

  assign cur_len = span(curs_q, cure_q, n);
  assign upd     = clr | obs_en;

  always_comb begin
    first_d = first_q; prev_d = prev_q; mvld_d = mvld_q; cnt_d = cnt_q;
    r0s_d = r0s_q; r0e_d = r0e_q; curs_d = curs_q; cure_d = cure_q;
    mids_d = mids_q; midl_d = midl_q;
    if (clr) begin
      first_d = 1'b0; prev_d = 1'b0; mvld_d = 1'b0; cnt_d = 2'd0;
    end else if (obs_en) begin
      if (obs_idx == '0) first_d = obs_pass;
      if (obs_pass && !prev_q) begin
        cnt_d  = (cnt_q == 2'd2) ? 2'd2 : cnt_q + 2'd1;
        curs_d = obs_idx;
      end
      if (obs_pass) cure_d = obs_idx;
      if (!obs_pass && prev_q) begin
        if (cnt_q == 2'd1) begin
          r0s_d = curs_q; r0e_d = cure_q;
        end else if (!mvld_q || cur_len > midl_q) begin
          mvld_d = 1'b1; mids_d = curs_q; midl_d = cur_len;
        end
      end
      prev_d = obs_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0; prev_q <= 1'b0; mvld_q <= 1'b0; cnt_q <= 2'd0;
      r0s_q <= '0; r0e_q <= '0; curs_q <= '0; cure_q <= '0; mids_q <= '0; midl_q <= '0;
    end else if (upd) begin
      first_q <= first_d; prev_q <= prev_d; mvld_q <= mvld_d; cnt_q <= cnt_d;
      r0s_q <= r0s_d; r0e_q <= r0e_d; curs_q <= curs_d; cure_q <= cure_d;
      mids_q <= mids_d; midl_q <= midl_d;
    end
  end

  // Final choice, read once the sweep has finished.
  logic          solo_open, multi, merge;
  logic [NW-1:0] z_s, z_e, b_s;
  logic [LW-1:0] b_l, sum;

  always_comb begin
    solo_open = (cnt_q == 2'd1) && prev_q;
    multi     = (cnt_q == 2'd2);
    merge     = multi && first_q && prev_q;
    z_s = (merge || solo_open) ? curs_q : r0s_q;
    z_e = solo_open ? cure_q : r0e_q;
    b_s = z_s;
    b_l = span(z_s, z_e, n);
    if (mvld_q && midl_q > b_l) begin
      b_s = mids_q; b_l = midl_q;
    end
    if (multi && prev_q && !merge && cur_len > b_l) begin
      b_s = curs_q; b_l = cur_len;
    end
    sum = LW'(b_s) + (b_l >> 1);
    if (sum >= LW'(n)) sum = sum - LW'(n);
    pick_idx   = NW'(sum);
    none_found = (cnt_q == 2'd0);
    all_pass   = (z_s == '0) && (z_e == n - NW'(1));
  end
endmodule

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl
  import tune_pkg::*;
#(
  parameter int MAX_N = 360,
  parameter int DEG_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAX_N+1)-1:0] num_phases,
  input  logic [DEG_W-1:0]           dflt_phase,
  output logic                       set_req,
  output logic [DEG_W-1:0]           set_deg,
  input  logic                       set_ack,
  output logic                       test_req,
  input  logic                       test_done,
  input  logic                       test_pass,
  output logic                       done,
  output logic                       error,
  output logic [DEG_W-1:0]           result_deg
);
  localparam int NW = $clog2(MAX_N + 1);
  localparam int SW = NW + 10;

  tune_state_t      st_q, st_d;
  logic [NW-1:0]    idx_q, idx_d, n_q, n_d, skip, pick_idx;
  logic [DEG_W-1:0] dflt_q, dflt_d, res_q, res_d, map_deg;
  logic             err_q, err_d, udf_q, udf_d;
  logic             trk_clr, trk_obs, none_found, all_pass, at_last;
  logic [NW:0]      jump, lim;

  tune_phase_map #(.NW(NW), .DEG_W(DEG_W)) u_map (
    .idx(idx_q), .n(n_q), .deg(map_deg)
  );

  tune_range_track #(.NW(NW)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .obs_en(trk_obs),
    .obs_idx(idx_q), .obs_pass(test_pass), .n(n_q),
    .none_found(none_found), .all_pass(all_pass), .pick_idx(pick_idx)
  );

  always_comb begin
    skip    = NW'((SW'(n_q) * SW'(20) + SW'(359)) / SW'(360));
    jump    = (NW+1)'(idx_q) + (NW+1)'(skip);
    lim     = (NW+1)'(n_q - NW'(1));
    at_last = (idx_q == n_q - NW'(1));
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; n_d = n_q; dflt_d = dflt_q;
    res_d = res_q; err_d = err_q; udf_d = udf_q;
    trk_clr = 1'b0; trk_obs = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        n_d = num_phases; dflt_d = dflt_phase; idx_d = '0;
        res_d = '0; err_d = 1'b0; udf_d = 1'b0;
        trk_clr = 1'b1; st_d = ST_SET;
      end
      ST_SET: if (set_ack) st_d = ST_TEST;
      ST_TEST: if (test_done) begin
        trk_obs = 1'b1;
        if (at_last)        st_d = ST_EVAL;
        else begin
          st_d = ST_SET;
          if (test_pass)    idx_d = idx_q + NW'(1);
          else if (jump >= lim) idx_d = n_q - NW'(1);
          else              idx_d = NW'(jump);
        end
      end
      ST_EVAL: begin
        if (none_found) begin
          err_d = 1'b1; st_d = ST_FIN;
        end else begin
          udf_d = all_pass; idx_d = pick_idx; st_d = ST_FSET;
        end
      end
      ST_FSET: if (set_ack) begin
        res_d = set_deg; st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; n_q <= NW'(1); dflt_q <= '0;
      res_q <= '0; err_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; n_q <= n_d; dflt_q <= dflt_d;
      res_q <= res_d; err_q <= err_d; udf_q <= udf_d;
    end
  end

  assign set_req    = (st_q == ST_SET) || (st_q == ST_FSET);
  assign set_deg    = (st_q == ST_FSET && udf_q) ? dflt_q : map_deg;
  assign test_req   = (st_q == ST_TEST);
  assign done       = (st_q == ST_FIN);
  assign error      = err_q;
  assign result_deg = res_q;
endmodule

// File: rtl/tune_sweep_chk.sv
module tune_sweep_chk #(
  parameter int DEG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_req,
  input logic             set_ack,
  input logic [DEG_W-1:0] set_deg,
  input logic             test_req,
  input logic             test_done,
  input logic             done,
  input logic             error
);
  a_r2_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
    set_req && !set_ack |=> set_req && $stable(set_deg));
  a_r2_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !test_done |=> test_req);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_req && test_req));
  a_r2_test_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> $past(set_ack));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_err_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !set_req && !test_req);
  a_r2_deg_range: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |-> set_deg <= DEG_W'(360));
endmodule

bind tune_sweep_ctrl tune_sweep_chk #(.DEG_W(DEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_ack(set_ack), .set_deg(set_deg),
  .test_req(test_req), .test_done(test_done), .done(done), .error(error)
);

// File: tb/tb_tune_sweep_ctrl.sv
module tb_tune_sweep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_N = 360;
  localparam int DEG_W = 9;
  localparam int NW = $clog2(MAX_N + 1);

  logic clk, rst_n, start, set_req, set_ack, test_req, test_done, test_pass, done, error;
  logic [NW-1:0] num_phases;
  logic [DEG_W-1:0] dflt_phase, set_deg, result_deg;

  int n_chk, n_err, cyc;
  bit mask [0:MAX_N-1];
  int vis [0:MAX_N-1];
  int nvis, exp_res;
  bit exp_err;
  int rs [0:MAX_N/2]; int re [0:MAX_N/2];

  tune_sweep_ctrl #(.MAX_N(MAX_N), .DEG_W(DEG_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_phases(num_phases),
    .dflt_phase(dflt_phase), .set_req(set_req), .set_deg(set_deg), .set_ack(set_ack),
    .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
    .done(done), .error(error), .result_deg(result_deg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int to_deg(int i, int n);
    return (i * 360 + n - 1) / n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference sweep over the current mask.
  task automatic ref_model(int n, int dflt);
    int i, cnt, best, bl, len, mid;
    bit v, prev, first;
    i = 0; cnt = 0; prev = 0; first = 0; v = 0; nvis = 0;
    while (i < n) begin
      vis[nvis] = i; nvis++;
      v = mask[i];
      if (i == 0) first = v;
      if (!prev && v) begin cnt++; rs[cnt-1] = i; end
      if (v) begin re[cnt-1] = i; i++; end
      else if (i == n - 1) i++;
      else begin
        i += (20 * n + 359) / 360;
        if (i >= n) i = n - 1;
      end
      prev = v;
    end
    exp_err = (cnt == 0); exp_res = 0;
    if (!exp_err) begin
      if (cnt > 1 && first && v) begin rs[0] = rs[cnt-1]; cnt--; end
      if (rs[0] == 0 && re[0] == n - 1) exp_res = dflt;
      else begin
        best = 0; bl = -1;
        for (int k = 0; k < cnt; k++) begin
          len = re[k] - rs[k] + 1;
          if (len < 0) len += n;
          if (bl < len) begin bl = len; best = k; end
        end
        mid = (rs[best] + bl / 2) % n;
        exp_res = to_deg(mid, n);
      end
    end
  endtask

  task automatic clr_mask();
    for (int k = 0; k < MAX_N; k++) mask[k] = 1'b0;
  endtask

  task automatic win(int s, int l, int n);
    for (int k = 0; k < l; k++) mask[(s + k) % n] = 1'b1;
  endtask

  task automatic run_case(int n, int dflt, bit poke, string tag);
    int k, fin_sets, d, guard;
    bit fin;
    ref_model(n, dflt);
    @(negedge clk);
    num_phases = NW'(n); dflt_phase = DEG_W'(dflt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; fin_sets = 0; fin = 0; guard = 0;
    while (!fin) begin
      guard++;
      if (guard > 20000 || cyc > 190000) begin
        check(0, {"R9 watchdog ", tag}, guard, 0);
        fin = 1;
      end else if (done) begin
        check(error == exp_err, {"R5 error flag ", tag}, error, exp_err);
        check(result_deg == DEG_W'(exp_res), {"R7 R8 result ", tag}, result_deg, exp_res);
        check(k == nvis, {"R4 visit count ", tag}, k, nvis);
        check(fin_sets == (exp_err ? 0 : 1), {"R5 final set count ", tag}, fin_sets, exp_err ? 0 : 1);
        @(negedge clk);
        check(!done, {"R9 done pulse ", tag}, done, 0);
        fin = 1;
      end else if (set_req) begin
        if (k < nvis)
          check(set_deg == DEG_W'(to_deg(vis[k], n)), {"R2 R3 R4 phase sequence ", tag},
                set_deg, to_deg(vis[k], n));
        else begin
          check(set_deg == DEG_W'(exp_res), {"R6 R7 R8 final phase ", tag}, set_deg, exp_res);
          fin_sets++;
        end
        d = $urandom % 3;
        repeat (d) @(negedge clk);
        set_ack = 1'b1;
        @(negedge clk);
        set_ack = 1'b0;
      end else if (test_req) begin
        if (poke) start = 1'b1;
        d = $urandom % 3;
        repeat (d) @(negedge clk);
        test_done = 1'b1;
        test_pass = (k < nvis) ? mask[vis[k]] : 1'b0;
        if (k >= nvis) check(0, {"R4 extra test ", tag}, k, nvis);
        k++;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0; start = 1'b0;
      end else @(negedge clk);
    end
  endtask

  always @(posedge clk) cyc++;

  initial begin
    int n, nw;
    void'($urandom(32'h5eed_1234));
    n_chk = 0; n_err = 0; cyc = 0;
    start = 0; set_ack = 0; test_done = 0; test_pass = 0;
    num_phases = NW'(8); dflt_phase = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !error && !set_req && !test_req, "R1 reset controls", done, 0);
    check(result_deg == '0, "R1 reset result", result_deg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!set_req && !test_req, "R1 idle after reset", set_req, 0);

    clr_mask(); win(0, 8, 8);             run_case(8, 45, 0, "all pass R7");
    clr_mask();                           run_case(8, 45, 0, "none R5");
    clr_mask(); win(6, 4, 8); win(3, 1, 8); run_case(8, 0, 0, "wrap R6");
    clr_mask(); win(1, 2, 10); win(5, 2, 10); run_case(10, 0, 0, "tie R8");
    clr_mask(); win(100, 30, 360);        run_case(360, 0, 0, "skip R4");
    clr_mask(); mask[359] = 1;            run_case(360, 7, 0, "last only R4");
    clr_mask(); mask[0] = 1;              run_case(1, 200, 0, "single pass R7");
    clr_mask();                           run_case(1, 200, 0, "single fail R5");
    clr_mask(); win(350, 40, 360); win(200, 10, 360);
                                          run_case(360, 0, 0, "wrap big R6");
    clr_mask(); win(0, 360, 360);         run_case(360, 90, 1, "busy start R9");

    for (int r = 0; r < 25; r++) begin
      n = (r % 6 == 0) ? 360 : 1 + ($urandom % 120);
      clr_mask();
      nw = $urandom % 4;
      for (int w = 0; w < nw; w++) win($urandom % n, 1 + ($urandom % (n / 3 + 1)), n);
      if ($urandom % 4 == 0) mask[$urandom % n] = 1'b1;
      run_case(n, $urandom % 360, r % 5 == 0, "random R3 R8");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule